// File: doc/BRIEF.md
# Serial Result Port with Selectable Data Clock

This block is the output stage of a sampling converter. It keeps a 12-bit result register that the conversion core loads at the end of each conversion. The word is two's complement: 0x7FF is the largest positive code, 0x800 the most negative and 0x000 midscale. The block sends the word most significant bit first on a single serial data line. It also drives an active-low busy flag that frames each conversion.

A mode input picks the source of the data clock. When the mode input is low, the block makes its own data clock. It sends the previous result while the next conversion runs, so busy acts as a frame strobe. When the mode input is high, an outside master supplies the clock. That clock is synchronised into the system clock domain, and each of its rising edges moves the next bit onto the line. An active-low select tri-states every output and blocks the outside clock. Tri-state pins are modelled as a value plus an output enable.

Top module: `serial_result_port`

## Requirements
- R1: After reset, busy_n is 1, ser_data and dclk_out are 0 and the result register is cleared.
- R2: A conv_start pulse while busy_n is 1 drives busy_n to 0 on the next cycle. load_req returns busy_n to 1 on the next cycle. A conv_start pulse while busy_n is 0 is ignored: busy_n stays 0 and the frame already running is neither restarted nor lengthened.
- R3: With ext_sel = 0, each conversion sends the previously loaded word on ser_data as exactly 12 dclk_out pulses, bit 11 first. Each pulse is high for HI_CYC cycles and each low phase before a pulse lasts LO_CYC cycles.
- R4: With ext_sel = 0, ser_data keeps the same bit from the cycle before a dclk_out rise until the first cycle after the matching fall.
- R5: With ext_sel = 0, ser_data and dclk_out are 0 whenever no frame is being sent.
- R6: With ext_sel = 1, each rising edge of ext_dclk (seen through a two-stage synchroniser) puts the next bit of the loaded word on ser_data, bit 11 first. The bit holds until the next rising edge, so it is valid on the falling edge in between. A load that is accepted sets ser_data to 0 and restarts the word at bit 11.
- R7: With ext_sel = 1, ser_data is 0 from the 13th rising edge onward.
- R8: With ext_sel = 1, a load_req that arrives while the synchronised ext_dclk is high and cs_n is 0 is dropped. The register keeps its old word and its read position, and the new word is lost. With cs_n = 1 the same load is accepted.
- R9: cs_n = 1 forces ser_data_oe, busy_oe and dclk_oe to 0. dclk_oe is 0 whenever ext_sel = 1. The internal frame still runs while the outputs are off.
- R10: With ext_sel = 1 and cs_n = 1, edges on ext_dclk do not advance the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sel | input | 1 | 0: internal data clock, 1: external data clock |
| cs_n | input | 1 | Active-low select; gates output enables and the external clock |
| conv_start | input | 1 | One-cycle pulse at the start of a conversion |
| load_req | input | 1 | One-cycle pulse at the end of a conversion; loads result_word |
| result_word | input | 12 | Two's-complement result from the conversion core |
| ext_dclk | input | 1 | Asynchronous external data clock |
| ser_data | output | 1 | Serial data value |
| ser_data_oe | output | 1 | Output enable for ser_data |
| busy_n | output | 1 | Low while a conversion runs |
| busy_oe | output | 1 | Output enable for busy_n |
| dclk_out | output | 1 | Internally generated data clock value |
| dclk_oe | output | 1 | Output enable for dclk_out |

## Verification
The bench sends sixteen words through each clock mode. The words include both full-scale codes, midscale, all ones and a spread of mixed patterns, so a swapped bit order, a stuck bit or an off-by-one shift shows up as a wrong bit at a known pulse. In internal mode it measures every pulse width and gap and the data on both sides of each edge. One extra start pulse is sent mid-frame to show that a restart would change the pulse count. In external mode it clocks past the twelfth bit to check the zero tail. It loads with the clock held high, once with select low and once with select high, so a dropped load and an accepted one are told apart. It toggles the clock while deselected to show that the register does not move.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    CG_IDLE,
    CG_LOW,
    CG_HIGH,
    CG_TAIL
  } cg_state_t;

  // Cycles one internal frame occupies: every bit has a low and a high
  // phase, plus one closing cycle that keeps the last bit after the fall.
  function automatic int unsigned frame_cycles(input int unsigned width,
                                                input int unsigned lo,
                                                input int unsigned hi);
    return width * (lo + hi) + 1;
  endfunction

  // Larger of two phase lengths, used to size the phase counter.
  function automatic int unsigned phase_max(input int unsigned a,
                                            input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srp_sync2.sv
module srp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic stage_a;
  logic stage_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= 1'b0;
      stage_b <= 1'b0;
    end else begin
      stage_a <= async_in;
      stage_b <= stage_a;
    end
  end

  assign sync_out = stage_b;
endmodule

// File: rtl/srp_int_clkgen.sv
module srp_int_clkgen
  import srp_pkg::*;
#(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned LO_CYC = 3,
  parameter int unsigned HI_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic dclk,
  output logic shift,
  output logic active
);
  localparam int unsigned PH_MAX = phase_max(LO_CYC, HI_CYC);
  localparam int unsigned CW     = $clog2(PH_MAX + 1);
  localparam int unsigned BW     = $clog2(WIDTH + 1);
  localparam int unsigned FRAME  = frame_cycles(WIDTH, LO_CYC, HI_CYC);
  localparam int unsigned FW     = $clog2(FRAME + 1);

  cg_state_t         state;
  logic [CW-1:0]     ph_cnt;
  logic [BW-1:0]     bit_idx;
  logic [FW-1:0]     frame_len;
  logic              lo_done;
  logic              hi_done;
  logic              last_bit;

  assign lo_done  = (ph_cnt == CW'(LO_CYC - 1));
  assign hi_done  = (ph_cnt == CW'(HI_CYC - 1));
  assign last_bit = (bit_idx == BW'(WIDTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CG_IDLE;
      ph_cnt  <= '0;
      bit_idx <= '0;
    end else if (abort) begin
      state   <= CG_IDLE;
      ph_cnt  <= '0;
      bit_idx <= '0;
    end else begin
      unique case (state)
        CG_IDLE: begin
          if (start) begin
            state   <= CG_LOW;
            ph_cnt  <= '0;
            bit_idx <= '0;
          end
        end
        CG_LOW: begin
          if (lo_done) begin
            state  <= CG_HIGH;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        CG_HIGH: begin
          if (hi_done) begin
            ph_cnt  <= '0;
            bit_idx <= bit_idx + 1'b1;
            state   <= last_bit ? CG_TAIL : CG_LOW;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        CG_TAIL: begin
          state   <= CG_IDLE;
          bit_idx <= '0;
        end
        default: state <= CG_IDLE;
      endcase
    end
  end

  // Frame-length counter kept for the checks below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 frame_len <= '0;
    else if (state == CG_IDLE)  frame_len <= '0;
    else                        frame_len <= frame_len + 1'b1;
  end

  assign dclk   = (state == CG_HIGH);
  assign active = (state != CG_IDLE);
  // The data moves one cycle after each fall, so the bit is still held
  // on the falling edge.
  assign shift  = ((state == CG_LOW) && (ph_cnt == '0) && (bit_idx != '0)) ||
                  (state == CG_TAIL);

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CG_TAIL) |-> (frame_len == FW'(FRAME - 1)));

  assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bit_idx <= BW'(WIDTH)));

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             load,
  input  logic             suppress,
  input  logic [WIDTH-1:0] word,
  input  logic             int_shift,
  input  logic             ext_shift,
  output logic             head_bit,
  output logic             ext_bit
);
  logic [WIDTH-1:0] sreg;
  logic             ext_q;
  logic             load_ok;
  logic             do_shift;

  assign load_ok  = load && !suppress;
  assign do_shift = ext_sel ? ext_shift : int_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      ext_q <= 1'b0;
    end else if (load_ok) begin
      sreg  <= word;
      ext_q <= 1'b0;
    end else if (do_shift) begin
      sreg <= {sreg[WIDTH-2:0], 1'b0};
      if (ext_sel) ext_q <= sreg[WIDTH-1];
    end
  end

  assign head_bit = sreg[WIDTH-1];
  assign ext_bit  = ext_q;

  assert_load_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !suppress) |=> (sreg == $past(word)));

  assert_load_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && suppress && !do_shift) |=> $stable(sreg));

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned LO_CYC = 3,
  parameter int unsigned HI_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             cs_n,
  input  logic             conv_start,
  input  logic             load_req,
  input  logic [WIDTH-1:0] result_word,
  input  logic             ext_dclk,
  output logic             ser_data,
  output logic             ser_data_oe,
  output logic             busy_n,
  output logic             busy_oe,
  output logic             dclk_out,
  output logic             dclk_oe
);
  logic ext_lvl;
  logic ext_gated;
  logic ext_gated_d;
  logic ext_rise;
  logic load_suppress;
  logic start_ok;
  logic int_dclk;
  logic int_shift;
  logic int_active;
  logic head_bit;
  logic ext_bit;
  logic busy_q;

  srp_sync2 u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_dclk),
    .sync_out (ext_lvl)
  );

  // Select gates the outside clock before edge detection.
  assign ext_gated = ext_lvl && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_gated_d <= 1'b0;
    else        ext_gated_d <= ext_gated;
  end

  assign ext_rise      = ext_gated && !ext_gated_d;
  assign load_suppress = ext_sel && ext_lvl && !cs_n;
  assign start_ok      = conv_start && busy_q && !load_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b1;
    else if (load_req) busy_q <= 1'b1;
    else if (start_ok) busy_q <= 1'b0;
  end

  srp_int_clkgen #(
    .WIDTH  (WIDTH),
    .LO_CYC (LO_CYC),
    .HI_CYC (HI_CYC)
  ) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_ok && !ext_sel),
    .abort  (load_req),
    .dclk   (int_dclk),
    .shift  (int_shift),
    .active (int_active)
  );

  srp_shifter #(
    .WIDTH (WIDTH)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_sel   (ext_sel),
    .load      (load_req),
    .suppress  (load_suppress),
    .word      (result_word),
    .int_shift (int_shift),
    .ext_shift (ext_rise),
    .head_bit  (head_bit),
    .ext_bit   (ext_bit)
  );

  assign ser_data    = ext_sel ? ext_bit : (int_active && head_bit);
  assign dclk_out    = !ext_sel && int_dclk;
  assign busy_n      = busy_q;
  assign ser_data_oe = !cs_n;
  assign busy_oe     = !cs_n;
  assign dclk_oe     = !cs_n && !ext_sel;

  assert_busy_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && conv_start && !load_req) |=> !busy_n);

  assert_restart_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && conv_start && !load_req && int_active && !ext_sel && !ext_sel)
      |=> $stable(busy_n));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !ext_sel) |-> (!dclk_out && !ser_data));

  assert_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && $rose(dclk_out)) |-> $stable(ser_data));

  assert_fall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && $fell(dclk_out)) |-> $stable(ser_data));

endmodule

// File: tb/serial_result_port_tb_top.sv
module serial_result_port_tb_top;
  localparam int W  = 12;
  localparam int LO = 3;
  localparam int HI = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext_sel = 1'b0;
  logic         cs_n = 1'b0;
  logic         conv_start = 1'b0;
  logic         load_req = 1'b0;
  logic [W-1:0] result_word = '0;
  logic         ext_dclk = 1'b0;
  logic         ser_data, ser_data_oe, busy_n, busy_oe, dclk_out, dclk_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_result_port #(.WIDTH(W), .LO_CYC(LO), .HI_CYC(HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .cs_n(cs_n),
    .conv_start(conv_start), .load_req(load_req), .result_word(result_word),
    .ext_dclk(ext_dclk), .ser_data(ser_data), .ser_data_oe(ser_data_oe),
    .busy_n(busy_n), .busy_oe(busy_oe), .dclk_out(dclk_out), .dclk_oe(dclk_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] word_at(input int i);
    case (i)
      0: return 12'h7FF;
      1: return 12'h800;
      2: return 12'h000;
      3: return 12'hFFF;
      default: return W'((i * 713) ^ 12'h5A3);
    endcase
  endfunction

  function automatic bit bit_of(input logic [W-1:0] w, input int k);
    return (k < W) ? w[W-1-k] : 1'b0;
  endfunction

  task automatic step(); @(negedge clk); endtask

  // One conversion in internal mode: previous word must come out.
  task automatic run_int(input logic [W-1:0] nxt, input logic [W-1:0] prev,
                         input bit cs_val, input bit restart);
    int pulses = 0, hi = 0, lo = 0;
    bit pd = 0, pdat = 0;
    cs_n = cs_val;
    conv_start = 1'b1; step(); conv_start = 1'b0;
    chk(busy_n == 1'b0, "R2 busy low after start", busy_n, 0);
    for (int c = 0; c < 79; c++) begin
      bit d = dclk_out;
      bit s = ser_data;
      if (d && !pd) begin
        chk(lo == LO, "R3 low phase length", lo, LO);
        chk(s == pdat && s == bit_of(prev, pulses), "R4 data at rise", s, bit_of(prev, pulses));
        hi = 1;
      end else if (d) hi++;
      if (!d && pd) begin
        chk(hi == HI, "R3 high phase length", hi, HI);
        chk(s == bit_of(prev, pulses), "R4 data after fall", s, bit_of(prev, pulses));
        pulses++;
        lo = 1;
      end else if (!d) lo++;
      if (c == 10) begin
        chk(ser_data_oe == !cs_val && busy_oe == !cs_val && dclk_oe == !cs_val,
            "R9 enables follow select", ser_data_oe, !cs_val);
      end
      pd = d; pdat = s;
      conv_start = restart && (c == 30);
      step();
      conv_start = 1'b0;
    end
    chk(pulses == W, "R3 pulse count", pulses, W);
    chk(busy_n == 1'b0, "R2 busy held through frame", busy_n, 0);
    chk(ser_data == 1'b0 && dclk_out == 1'b0, "R5 quiet after frame", ser_data, 0);
    result_word = nxt; load_req = 1'b1; step(); load_req = 1'b0;
    chk(busy_n == 1'b1, "R2 busy high after load", busy_n, 1);
    step();
    chk(ser_data == 1'b0 && dclk_out == 1'b0, "R5 quiet between", dclk_out, 0);
    cs_n = 1'b0;
  endtask

  task automatic ext_conv_load(input logic [W-1:0] w);
    conv_start = 1'b1; step(); conv_start = 1'b0;
    repeat (20) step();
    result_word = w; load_req = 1'b1; step(); load_req = 1'b0;
    step();
  endtask

  task automatic ext_read(input logic [W-1:0] w, input int first, input int n);
    for (int k = first; k < first + n; k++) begin
      ext_dclk = 1'b1; repeat (4) step();
      if (k < W) chk(ser_data == bit_of(w, k), "R6 bit after rise", ser_data, bit_of(w, k));
      else       chk(ser_data == 1'b0, "R7 zero past last bit", ser_data, 0);
      ext_dclk = 1'b0; repeat (4) step();
      if (k < W) chk(ser_data == bit_of(w, k), "R6 bit at fall", ser_data, bit_of(w, k));
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    chk(busy_n == 1'b1, "R1 busy idle", busy_n, 1);
    chk(ser_data == 1'b0 && dclk_out == 1'b0, "R1 outputs low", ser_data, 0);
    chk(ser_data_oe && busy_oe && dclk_oe, "R9 enabled when selected", dclk_oe, 1);

    // Internal mode: first frame sends the reset value (zero).
    run_int(word_at(0), '0, 1'b0, 1'b0);
    for (int i = 1; i < 16; i++) run_int(word_at(i), word_at(i-1), 1'b0, i == 3);
    // Deselected conversion: outputs off, its frame is consumed.
    run_int(12'h3C5, word_at(15), 1'b1, 1'b0);
    run_int(12'hA5A, 12'h3C5, 1'b0, 1'b0);

    // External mode.
    ext_sel = 1'b1; step();
    chk(dclk_oe == 1'b0, "R9 no clock drive in external mode", dclk_oe, 0);
    ext_conv_load(word_at(0));
    ext_read(word_at(0), 0, 14);   // R6, R7
    for (int i = 1; i < 16; i++) begin
      ext_conv_load(word_at(i));
      ext_read(word_at(i), 0, W);
    end
    // Partial read then reload restarts at bit 11.
    ext_conv_load(12'h9B4);
    ext_read(12'h9B4, 0, 5);
    ext_conv_load(12'h1E7);
    chk(ser_data == 1'b0, "R6 accepted load clears line", ser_data, 0);
    ext_read(12'h1E7, 0, W);

    // R8: load while clock high and selected is dropped.
    ext_conv_load(12'hC39);
    conv_start = 1'b1; step(); conv_start = 1'b0;
    ext_dclk = 1'b1; repeat (4) step();
    chk(ser_data == bit_of(12'hC39, 0), "R8 first bit before drop", ser_data, bit_of(12'hC39, 0));
    result_word = 12'h2D6; load_req = 1'b1; step(); load_req = 1'b0;
    repeat (3) step();
    ext_dclk = 1'b0; repeat (4) step();
    ext_read(12'hC39, 1, W - 1);

    // R8: same load with select high is taken.
    cs_n = 1'b1; ext_dclk = 1'b1; repeat (4) step();
    conv_start = 1'b1; step(); conv_start = 1'b0;
    result_word = 12'h6B1; load_req = 1'b1; step(); load_req = 1'b0;
    chk(ser_data_oe == 1'b0 && busy_oe == 1'b0, "R9 outputs off when deselected", ser_data_oe, 0);
    ext_dclk = 1'b0; repeat (4) step();
    cs_n = 1'b0; step();
    ext_read(12'h6B1, 0, W);

    // R10: clocks while deselected do not advance the word.
    ext_conv_load(12'h4E2);
    cs_n = 1'b1;
    for (int t = 0; t < 5; t++) begin
      ext_dclk = 1'b1; repeat (4) step();
      ext_dclk = 1'b0; repeat (4) step();
    end
    cs_n = 1'b0; step();
    chk(ser_data == 1'b0, "R10 line unchanged while deselected", ser_data, 0);
    ext_read(12'h4E2, 0, W);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule